// File: doc/BRIEF.md
# Quadrature Encoder Position Counter with Byte-Wide Host Port

This block counts the position of an incremental shaft encoder. The two phase inputs, A and B, are resynchronised to the core clock and decoded in x4 mode. Every valid edge on either phase moves a 24-bit up/down register by one. The direction comes from which phase leads. The register wraps modulo 2^24, and a sticky flag records each wrap.

A host reaches the block through an 8-bit bus with two ports, chosen by `host_ctrl`. A write to the control port is a command. The commands reset the byte pointer, clear the counter, load it from a preset, take a snapshot of it, clear the wrap flag, copy a prescaler byte to the filter divider output, or enable x4 counting. The data port shares one byte pointer that advances after each access and stops at the most significant byte. Reads on the data port return bytes of the snapshot. Writes on the data port fill the preset register.

A host reads a position in a fixed order. It resets the pointer, takes a snapshot, and then reads three bytes, least significant first. Counting goes on while the host reads, so the three bytes always come from one coherent value.

Top module: `qenc_counter_if`

## Requirements
- R1: After a synchronous active-low reset, the following are zero: the counter, the snapshot, the preset, the byte pointer, the wrap flag and `filt_div`. Counting is disabled.
- R2: Phase edges change nothing until command 0x38 has been written. After that command, every valid edge of A and every valid edge of B changes the count by exactly one.
- R3: The state {A,B} stepping 00→10→11→01→00 (A leads) counts up. The reverse order (B leads) counts down.
- R4: A transition in which A and B change in the same sampled cycle leaves the count unchanged.
- R5: Command 0x10 copies the live count into the snapshot. Data-port reads return the snapshot even while counting continues.
- R6: Command 0x01 returns the byte pointer to byte 0. Data-port reads then give snapshot bits 7:0, then 15:8, then 23:16. Further reads keep returning bits 23:16.
- R7: Command 0x02 clears the count to zero.
- R8: A data-port write stores the byte into preset byte N, where N is the current pointer, and then advances the pointer. Command 0x08 loads the preset into the counter.
- R9: The count wraps modulo 2^24, so one step down from 0 reads 0xFFFFFF. The `enc_eflag` flag is set on a wrap in either direction and stays set.
- R10: Command 0x06 clears `enc_eflag`.
- R11: Command 0x18 copies preset bits 7:0 to `filt_div`.
- R12: Other command codes leave the count, the flag and `filt_div` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| host_ctrl | input | 1 | 1 selects the control port, 0 selects the data port |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Command or data byte |
| host_rdata | output | 8 | Snapshot byte at the current pointer |
| enc_eflag | output | 1 | Sticky wrap flag |
| filt_div | output | 8 | Filter clock divider value |

## Verification
The bench builds the block with its default widths only: a 24-bit counter made of three 8-bit bytes. Loading the preset with all ones or stepping down from zero brings both wrap directions into reach within a few cycles. With three bytes, the fourth read, which exercises pointer saturation, takes only a handful of host accesses. Expected bytes come from a counter model kept in the bench, and the bench compares them against the data-port output as each read occurs.

// File: rtl/qenc_pkg.sv
// Package: shared command codes and default widths for the quadrature
// encoder counter. Assumes one command per control-port write.
package qenc_pkg;
    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned CNT_W_DEF  = 24;

    localparam logic [7:0] CMD_PTR_RST  = 8'h01;
    localparam logic [7:0] CMD_CNT_CLR  = 8'h02;
    localparam logic [7:0] CMD_FLAG_CLR = 8'h06;
    localparam logic [7:0] CMD_LOAD     = 8'h08;
    localparam logic [7:0] CMD_SNAP     = 8'h10;
    localparam logic [7:0] CMD_DIV_XFER = 8'h18;
    localparam logic [7:0] CMD_QUAD_X4  = 8'h38;
endpackage

// File: rtl/qenc_sync_decode.sv
// Module: two-flop synchroniser per phase plus x4 quadrature edge decoder.
// Assumes phases change no faster than once per two core clocks.
// A-leading order (00,10,11,01 on {A,B}) yields step_up; the reverse yields
// step_dn; a double change yields neither.
module qenc_sync_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic step_up,
    output logic step_dn
);
    logic [1:0] ab_s1, ab_s2, ab_prev;

    // Resynchronise both phases and remember the last settled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_s1   <= '0;
            ab_s2   <= '0;
            ab_prev <= '0;
        end else begin
            ab_s1   <= {enc_a, enc_b};
            ab_s2   <= ab_s1;
            ab_prev <= ab_s2;
        end
    end

    // Classify the move between the previous and current settled state.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        case ({ab_prev, ab_s2})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step_up = 1'b1;
            4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: step_dn = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/qenc_count_core.sv
// Module: position register with clear, preset load, up/down step and a
// sticky wrap flag. Assumes at most one of the steps is high per cycle.
// Clear beats load, load beats stepping; a wrap beats a flag clear.
module qenc_count_core #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             cnt_clr,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] preset,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             eflag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic go_up, go_dn, wrap_evt;

    // Qualify steps with the enable and detect a wrap in either direction.
    always_comb begin
        go_up    = count_en && step_up;
        go_dn    = count_en && step_dn;
        wrap_evt = (go_up && cnt == CNT_MAX) || (go_dn && cnt == '0);
    end

    // Update the position register.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (cnt_clr)  cnt <= '0;
        else if (cnt_load) cnt <= preset;
        else if (go_up)    cnt <= cnt + 1'b1;
        else if (go_dn)    cnt <= cnt - 1'b1;
    end

    // Hold the sticky wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        eflag <= 1'b0;
        else if (wrap_evt) eflag <= 1'b1;
        else if (flag_clr) eflag <= 1'b0;
    end
endmodule

// File: rtl/qenc_host_port.sv
// Module: byte-wide host side. Decodes commands, keeps the saturating byte
// pointer, the preset register, the snapshot latch, the divider value and
// the x4 enable. Assumes host_wr and host_rd are single-cycle strobes.
module qenc_host_port
    import qenc_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              host_ctrl,
    input  logic                              host_wr,
    input  logic                              host_rd,
    input  logic [BYTE_W-1:0]                 host_wdata,
    input  logic [CNT_W-1:0]                  cnt,
    output logic [BYTE_W-1:0]                 host_rdata,
    output logic [CNT_W-1:0]                  preset,
    output logic [BYTE_W-1:0]                 filt_div,
    output logic [$clog2(CNT_W/BYTE_W)-1:0]   bptr,
    output logic                              quad_en,
    output logic                              cmd_clr,
    output logic                              cmd_load,
    output logic                              cmd_fclr
);
    localparam int unsigned NBYTES = CNT_W / BYTE_W;
    localparam int unsigned PTR_W  = $clog2(NBYTES);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

    logic ctrl_wr, data_wr, data_rd;
    logic cmd_prst, cmd_snap, cmd_div, cmd_quad;
    logic [CNT_W-1:0] snap;

    // Split strobes by port and decode the command byte.
    always_comb begin
        ctrl_wr  = host_wr && host_ctrl;
        data_wr  = host_wr && !host_ctrl;
        data_rd  = host_rd && !host_ctrl;
        cmd_prst = ctrl_wr && (host_wdata == CMD_PTR_RST);
        cmd_clr  = ctrl_wr && (host_wdata == CMD_CNT_CLR);
        cmd_fclr = ctrl_wr && (host_wdata == CMD_FLAG_CLR);
        cmd_load = ctrl_wr && (host_wdata == CMD_LOAD);
        cmd_snap = ctrl_wr && (host_wdata == CMD_SNAP);
        cmd_div  = ctrl_wr && (host_wdata == CMD_DIV_XFER);
        cmd_quad = ctrl_wr && (host_wdata == CMD_QUAD_X4);
    end

    // Byte pointer: reset by command, advance on data access, stop at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         bptr <= '0;
        else if (cmd_prst)                                  bptr <= '0;
        else if ((data_wr || data_rd) && bptr != PTR_LAST)  bptr <= bptr + 1'b1;
    end

    // Preset bytes, one register slice per pointer position.
    for (genvar i = 0; i < NBYTES; i++) begin : g_preset
        always_ff @(posedge clk) begin
            if (!rst_n)
                preset[i*BYTE_W +: BYTE_W] <= '0;
            else if (data_wr && bptr == PTR_W'(i))
                preset[i*BYTE_W +: BYTE_W] <= host_wdata;
        end
    end

    // Snapshot latch of the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap <= '0;
        else if (cmd_snap) snap <= cnt;
    end

    // Filter divider value and x4 counting enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_div <= '0;
            quad_en  <= 1'b0;
        end else begin
            if (cmd_div)  filt_div <= preset[BYTE_W-1:0];
            if (cmd_quad) quad_en  <= 1'b1;
        end
    end

    // Present the snapshot byte selected by the pointer.
    always_comb begin
        host_rdata = '0;
        for (int k = 0; k < NBYTES; k++)
            if (bptr == PTR_W'(k)) host_rdata = snap[k*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/qenc_counter_if.sv
// Module: top of the quadrature encoder counter. Joins the phase decoder,
// the position core and the host port. Assumes CNT_W is a multiple of BYTE_W.
module qenc_counter_if
    import qenc_pkg::*;
#(
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned BYTE_W = BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              host_ctrl,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              enc_eflag,
    output logic [BYTE_W-1:0] filt_div
);
    localparam int unsigned PTR_W = $clog2(CNT_W / BYTE_W);

    logic             step_up, step_dn, quad_en;
    logic             cmd_clr, cmd_load, cmd_fclr;
    logic [CNT_W-1:0] cnt, preset;
    logic [PTR_W-1:0] bptr;

    qenc_sync_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .enc_a   (enc_a),
        .enc_b   (enc_b),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    qenc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (quad_en),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .cnt_clr  (cmd_clr),
        .cnt_load (cmd_load),
        .preset   (preset),
        .flag_clr (cmd_fclr),
        .cnt      (cnt),
        .eflag    (enc_eflag)
    );

    qenc_host_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_ctrl  (host_ctrl),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .cnt        (cnt),
        .host_rdata (host_rdata),
        .preset     (preset),
        .filt_div   (filt_div),
        .bptr       (bptr),
        .quad_en    (quad_en),
        .cmd_clr    (cmd_clr),
        .cmd_load   (cmd_load),
        .cmd_fclr   (cmd_fclr)
    );
endmodule

// File: rtl/qenc_counter_chk.sv
// Module: protocol checker for qenc_counter_if, attached by bind.
// Observes the host strobes, decoder steps and the block's inner state.
module qenc_counter_chk
    import qenc_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned PTR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ctrl,
    input logic              host_wr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic              step_up,
    input logic              step_dn,
    input logic              quad_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [PTR_W-1:0]  bptr,
    input logic              enc_eflag,
    input logic [BYTE_W-1:0] host_rdata
);
    localparam int unsigned NBYTES = CNT_W / BYTE_W;

    logic ctrl_wr;
    assign ctrl_wr = host_wr && host_ctrl;

    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bptr <= PTR_W'(NBYTES - 1));

    p_ptr_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && host_wdata == CMD_PTR_RST |=> bptr == '0);

    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && host_wdata == CMD_CNT_CLR |=> cnt == '0);

    p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && host_wdata == CMD_SNAP) && !ctrl_wr && !host_wr |=> $stable(host_rdata) || $changed(bptr));

    p_no_dual_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_en && !ctrl_wr |=> $stable(cnt));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_eflag && !(ctrl_wr && host_wdata == CMD_FLAG_CLR) |=> enc_eflag);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && host_wdata == CMD_FLAG_CLR && !step_up && !step_dn |=> !enc_eflag);
endmodule

bind qenc_counter_if qenc_counter_chk #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ctrl  (host_ctrl),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .quad_en    (quad_en),
    .cnt        (cnt),
    .bptr       (bptr),
    .enc_eflag  (enc_eflag),
    .host_rdata (host_rdata)
);

// File: tb/qenc_counter_if_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for qenc_counter_if. Driver tasks queue expected read
// bytes; a monitor compares them against host_rdata on each data read.
module qenc_counter_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_a = 1'b0, enc_b = 1'b0;
    logic       host_ctrl = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, filt_div;
    logic       enc_eflag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] ab = 2'b00;

    always #2.5 clk = ~clk;

    qenc_counter_if u_qenc_counter_if (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .host_ctrl(host_ctrl), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .enc_eflag(enc_eflag), .filt_div(filt_div)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each data-port read against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && host_rd && !host_ctrl) begin
            if (exp_q.size() == 0) check(1'b0, "unexpected read", host_rdata, 0);
            else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    task automatic host_cmd(input logic [7:0] code);
        @(posedge clk); #1;
        host_ctrl = 1'b1; host_wr = 1'b1; host_wdata = code;
        @(posedge clk); #1;
        host_ctrl = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_wbyte(input logic [7:0] b);
        @(posedge clk); #1;
        host_wr = 1'b1; host_wdata = b;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_rbyte(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    // Pointer reset, snapshot, three bytes least significant first.
    task automatic read_count(input logic [23:0] e, input string tag);
        host_cmd(8'h01);
        host_cmd(8'h10);
        host_rbyte(e[7:0],   tag);
        host_rbyte(e[15:8],  tag);
        host_rbyte(e[23:16], tag);
    endtask

    task automatic load_preset(input logic [23:0] v);
        host_cmd(8'h01);
        host_wbyte(v[7:0]);
        host_wbyte(v[15:8]);
        host_wbyte(v[23:16]);
        host_cmd(8'h08);
    endtask

    // One valid quadrature step; A-leading order counts up.
    task automatic qstep(input bit up);
        if (up) case (ab)
            2'b00: ab = 2'b10; 2'b10: ab = 2'b11;
            2'b11: ab = 2'b01; default: ab = 2'b00;
        endcase
        else case (ab)
            2'b00: ab = 2'b01; 2'b01: ab = 2'b11;
            2'b11: ab = 2'b10; default: ab = 2'b00;
        endcase
        @(posedge clk); #1;
        {enc_a, enc_b} = ab;
        repeat (5) @(posedge clk);
    endtask

    task automatic qbad();
        ab = ~ab;
        @(posedge clk); #1;
        {enc_a, enc_b} = ab;
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(enc_eflag == 1'b0, "R1 flag at reset", enc_eflag, 0);
        check(filt_div == 8'h00, "R1 divider at reset", filt_div, 0);
        check(host_rdata == 8'h00, "R1 snapshot at reset", host_rdata, 0);
        read_count(24'h0, "R1 count at reset");

        // R2: edges before x4 enable do nothing.
        repeat (4) qstep(1'b1);
        read_count(24'h0, "R2 edges ignored before enable");
        host_cmd(8'h38);
        repeat (4) qstep(1'b1);
        read_count(24'h4, "R2 x4 count up");

        // R3 and R9: count down through zero.
        repeat (6) qstep(1'b0);
        read_count(24'hFFFFFE, "R3 count down with wrap");
        @(negedge clk);
        check(enc_eflag == 1'b1, "R9 flag on down wrap", enc_eflag, 1);
        host_cmd(8'h06);
        @(negedge clk);
        check(enc_eflag == 1'b0, "R10 flag clear", enc_eflag, 0);

        // R4: both phases change at once.
        qbad();
        qbad();
        read_count(24'hFFFFFE, "R4 double change ignored");

        // R5 and R6: the snapshot holds while counting continues; the pointer saturates.
        host_cmd(8'h01);
        host_cmd(8'h10);
        repeat (3) qstep(1'b1);
        host_rbyte(8'hFE, "R5 snapshot byte0");
        host_rbyte(8'hFF, "R5 snapshot byte1");
        host_rbyte(8'hFF, "R5 snapshot byte2");
        host_rbyte(8'hFF, "R6 pointer saturates");
        @(negedge clk);
        check(enc_eflag == 1'b1, "R9 flag on up wrap, sticky", enc_eflag, 1);
        read_count(24'h000001, "R5 live count after snapshot");

        // R7: clear.
        host_cmd(8'h02);
        read_count(24'h0, "R7 counter clear");

        // R8 and R11: preset load and divider transfer.
        load_preset(24'h123456);
        read_count(24'h123456, "R8 preset load");
        host_cmd(8'h18);
        @(negedge clk);
        check(filt_div == 8'h56, "R11 divider transfer", filt_div, 8'h56);

        // R9: wrap upward from all ones.
        host_cmd(8'h06);
        load_preset(24'hFFFFFF);
        @(negedge clk);
        check(enc_eflag == 1'b0, "R9 flag clear before up wrap", enc_eflag, 0);
        qstep(1'b1);
        @(negedge clk);
        check(enc_eflag == 1'b1, "R9 flag on up wrap", enc_eflag, 1);
        read_count(24'h0, "R9 modulo wrap up");
        qstep(1'b0);
        read_count(24'hFFFFFF, "R9 minus one reads all ones");

        // R12: unknown command codes have no effect.
        host_cmd(8'h77);
        host_cmd(8'h00);
        host_cmd(8'h20);
        read_count(24'hFFFFFF, "R12 count unchanged");
        @(negedge clk);
        check(enc_eflag == 1'b1, "R12 flag unchanged", enc_eflag, 1);
        check(filt_div == 8'h56, "R12 divider unchanged", filt_div, 8'h56);

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule